// File: doc/BRIEF.md
# Bus-Triggered Clock Source Switcher

This block sits between two clock sources and the clock tree of a bus subsystem. Normally the subsystem runs from a free-running fast clock. A second, slow clock is produced by an external stepping agent that advances a modelled peripheral one edge at a time. The block watches the address and control phase of an AHB-Lite bus. When a valid transfer falls inside a programmable address window, it hands the system clock over to the stepped source, so that the data phase runs in lockstep with the peripheral model. As soon as that data phase finishes, it hands the clock back to the fast source.

The handover is glitch-free. Each source has its own enable, brought through a synchroniser clocked by that source and then through a falling-edge stage. A source is enabled only after the other has been seen disabled. A status flag tells the surrounding logic when the stepped clock really drives the output. Two registers hold the inclusive lower and upper bounds of the window. They are written through a small port clocked by the fast clock, and only while the fast clock drives the output. The stepping agent must keep issuing stepped edges until the fast clock has returned, because the release handshake is carried by those edges.

Top module: `busclk_switch`

## Requirements
- R1: After reset the fast clock drives `clk_sys`, `step_active` is low, and the window is empty: the upper bound resets to all zeros and the lower bound to all ones, so no address starts a switch.
- R2: An address phase starts a switch only when all of these hold: `hsel` is 1, `hready` is 1, and `htrans` is NONSEQ (2'b10) or SEQ (2'b11). Every other case does not start a switch, including IDLE (2'b00), BUSY (2'b01), `hsel` at 0 and `hready` at 0.
- R3: After such a hit, `clk_sys` stops carrying fast pulses. Once the stepping agent supplies edges, every stepped pulse appears on `clk_sys`.
- R4: The access completes at the first gated stepped rising edge that samples `hready` high, unless a new window hit is presented in that same cycle. After completion the fast clock returns to `clk_sys` and `step_active` falls.
- R5: While `hready` stays low in the data phase, the stepped clock stays selected, however many stepped edges arrive.
- R6: Back-to-back window hits presented with `hready` high keep the stepped clock selected, with no return to the fast clock between them.
- R7: The two source enables are never both active, and `clk_sys` never shows a pulse shorter than a half period of the source that produced it.
- R8: `step_active` rises only after the fast enable is off and the stepped enable is on, and falls only after the fast enable is back on. During the gap between the hit and the first stepped edge it stays low.
- R9: A write with `cfg_wr` high sets the lower bound when `cfg_sel`=0 and the upper bound when `cfg_sel`=1, sampled on a `clk_fast` rising edge. A write attempted while a stepped period is pending or active is ignored.
- R10: Both bounds are inclusive. A window with equal bounds matches exactly one address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Free-running fast source; also clocks the register port and control |
| clk_step | input | 1 | Slow source driven by the external stepping agent |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| haddr | input | ADDR_W | Bus address of the current address phase |
| htrans | input | 2 | Transfer type (IDLE, BUSY, NONSEQ, SEQ) |
| hsel | input | 1 | Slave select for the watched region |
| hready | input | 1 | Bus ready; high when the previous data phase ends |
| cfg_wr | input | 1 | Window register write strobe |
| cfg_sel | input | 1 | 0 selects the lower bound, 1 the upper bound |
| cfg_wdata | input | ADDR_W | Write data for the selected bound |
| clk_sys | output | 1 | Gated, glitch-free system clock |
| step_active | output | 1 | High while the stepped source drives `clk_sys` |

## Verification
Assertions check on every cycle that the two enables are never both active, that the status flag rises only with the fast enable off and holds while a request is pending, that completion is flagged only after a ready, non-hit, gated stepped edge, and that the window bounds do not move while writes are blocked. Only the bench's scenarios can show the behaviour seen from outside: which bus patterns start a switch, that `clk_sys` falls silent and then carries exactly the stepped pulses, that wait states and back-to-back hits hold the stepped clock, that the inclusive bounds and ignored writes behave as stated, and that no runt pulse ever reaches the output.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the bus-triggered clock switcher.
package bcs_pkg;

  // Transfer type codes on the watched bus.
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  // Smallest synchroniser depth the handover is built for.
  localparam int MIN_SYNC = 2;

  // An address phase is live when selected, ready and carrying real data.
  function automatic logic xfer_live(input logic [1:0] tr,
                                     input logic       sel,
                                     input logic       rdy);
    return sel && rdy && ((tr == TR_NONSEQ) || (tr == TR_SEQ));
  endfunction

endpackage

// File: rtl/bcs_sync.sv
`timescale 1ns/1ps
// Level synchroniser: a chain of STAGES rising-edge flops in the clk domain.
module bcs_sync #(
  parameter int STAGES = 2,
  parameter bit INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] stage_q;

  generate
    for (genvar i = 0; i <= LAST; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= INIT;
          else        stage_q[0] <= d;
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= INIT;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[LAST];
endmodule

// File: rtl/bcs_gate_side.sv
`timescale 1ns/1ps
// One side of the glitch-free clock mux. The request is masked by the other
// side's enable, synchronised in this side's clock, then retimed on the
// falling edge so that the AND gate only ever changes while clk is low.
module bcs_gate_side #(
  parameter int STAGES = 2,
  parameter bit INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic other_en,
  output logic en_g,
  output logic gclk
);
  logic arm;
  logic arm_sync;

  // Enable this side only once the other side has been seen off.
  assign arm = want & ~other_en;

  bcs_sync #(.STAGES(STAGES), .INIT(INIT)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (arm),
    .q    (arm_sync)
  );

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_g <= INIT;
    else        en_g <= arm_sync;
  end

  assign gclk = clk & en_g;
endmodule

// File: rtl/bcs_window.sv
`timescale 1ns/1ps
// Window bound registers and the address-phase hit detector.
module bcs_window
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              wr_allow,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hsel,
  input  logic              hready,
  output logic              hit
);
  logic [ADDR_W-1:0] lo_q;
  logic [ADDR_W-1:0] hi_q;
  logic              wr_lo;
  logic              wr_hi;

  // Inclusive bounds check.
  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] lo,
                                     input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  assign wr_lo = wr_en & wr_allow & ~wr_sel;
  assign wr_hi = wr_en & wr_allow &  wr_sel;

  // Reset leaves the upper bound below the lower bound: an empty window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '1;
      hi_q <= '0;
    end else begin
      if (wr_lo) lo_q <= wr_data;
      if (wr_hi) hi_q <= wr_data;
    end
  end

  assign hit = xfer_live(htrans, hsel, hready) && in_window(haddr, lo_q, hi_q);

  // R9: bounds are frozen whenever writes are blocked.
  p_cfg_frozen_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    !wr_allow |=> ($stable(lo_q) && $stable(hi_q)));

endmodule

// File: rtl/bcs_step_track.sv
`timescale 1ns/1ps
// Stepped-domain completion tracker: flags the end of the window access and
// holds the flag until the fast side withdraws its request.
module bcs_step_track #(
  parameter int STAGES = 2
) (
  input  logic clk_step,
  input  logic rst_n,
  input  logic req_async,
  input  logic en_gate,
  input  logic hready,
  input  logic hit,
  output logic done_q
);
  logic req_s;
  logic finish;

  bcs_sync #(.STAGES(STAGES), .INIT(1'b0)) u_req_sync (
    .clk  (clk_step),
    .rst_n(rst_n),
    .d    (req_async),
    .q    (req_s)
  );

  // A gated edge with ready high ends the data phase, unless it also starts
  // another window access.
  assign finish = en_gate & hready & ~hit;

  always_ff @(posedge clk_step or negedge rst_n) begin
    if (!rst_n)      done_q <= 1'b0;
    else if (!req_s) done_q <= 1'b0;
    else if (finish) done_q <= 1'b1;
  end

  // R4: completion only after a ready, gated stepped edge.
  p_done_on_ready_r4 : assert property (@(posedge clk_step) disable iff (!rst_n)
    $rose(done_q) |-> ($past(hready) && $past(en_gate)));

  // R6: a window hit in the same cycle never ends the stepped period.
  p_done_not_hit_r6 : assert property (@(posedge clk_step) disable iff (!rst_n)
    $rose(done_q) |-> !$past(hit));

endmodule

// File: rtl/busclk_switch.sv
`timescale 1ns/1ps
// Top: bus-triggered switch between a fast clock and a stepped clock.
module busclk_switch
  import bcs_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_fast,
  input  logic              clk_step,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hsel,
  input  logic              hready,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              clk_sys,
  output logic              step_active
);
  localparam int SYNC_N = (SYNC_STAGES < MIN_SYNC) ? MIN_SYNC : SYNC_STAGES;

  // Named internal events, used by the assertions below.
  logic hit;
  logic en_fast_g;
  logic en_step_g;
  logic gclk_fast;
  logic gclk_step;
  logic req_q;
  logic status_q;
  logic done_q;
  logic done_f;
  logic step_on_f;
  logic wr_allow;
  logic fast_want;
  logic step_want;
  logic accept_hit;

  // ---------------- window and hit detection (fast domain) ----------------
  assign wr_allow = en_fast_g & ~req_q & ~status_q;

  bcs_window #(.ADDR_W(ADDR_W)) u_window (
    .clk     (clk_fast),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_wdata),
    .wr_allow(wr_allow),
    .haddr   (haddr),
    .htrans  (htrans),
    .hsel    (hsel),
    .hready  (hready),
    .hit     (hit)
  );

  // ---------------- request handshake (fast domain) ----------------
  bcs_sync #(.STAGES(SYNC_N), .INIT(1'b0)) u_done_sync (
    .clk  (clk_fast),
    .rst_n(rst_n),
    .d    (done_q),
    .q    (done_f)
  );

  // A hit counts only while the fast clock drives the bus and the previous
  // stepped period has fully released.
  assign accept_hit = hit & en_fast_g & ~done_f;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n)          req_q <= 1'b0;
    else if (done_f)     req_q <= 1'b0;
    else if (accept_hit) req_q <= 1'b1;
  end

  // ---------------- glitch-free mux ----------------
  assign fast_want = ~req_q;
  assign step_want = req_q & ~done_q;

  bcs_gate_side #(.STAGES(SYNC_N), .INIT(1'b1)) u_fast_side (
    .clk     (clk_fast),
    .rst_n   (rst_n),
    .want    (fast_want),
    .other_en(en_step_g),
    .en_g    (en_fast_g),
    .gclk    (gclk_fast)
  );

  bcs_gate_side #(.STAGES(SYNC_N), .INIT(1'b0)) u_step_side (
    .clk     (clk_step),
    .rst_n   (rst_n),
    .want    (step_want),
    .other_en(en_fast_g),
    .en_g    (en_step_g),
    .gclk    (gclk_step)
  );

  assign clk_sys = gclk_fast | gclk_step;

  // ---------------- completion (stepped domain) ----------------
  bcs_step_track #(.STAGES(SYNC_N)) u_track (
    .clk_step (clk_step),
    .rst_n    (rst_n),
    .req_async(req_q),
    .en_gate  (en_step_g),
    .hready   (hready),
    .hit      (hit),
    .done_q   (done_q)
  );

  // ---------------- status (fast domain) ----------------
  bcs_sync #(.STAGES(SYNC_N), .INIT(1'b0)) u_stepon_sync (
    .clk  (clk_fast),
    .rst_n(rst_n),
    .d    (en_step_g),
    .q    (step_on_f)
  );

  // Rise once fast is off and stepped is seen on; fall once fast is back.
  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n)                        status_q <= 1'b0;
    else if (!en_fast_g && step_on_f)  status_q <= 1'b1;
    else if (en_fast_g && !step_on_f)  status_q <= 1'b0;
  end

  assign step_active = status_q;

  // ---------------- assertions ----------------
  // R7: the two enables never overlap, seen from either clock.
  p_excl_fast_r7 : assert property (@(posedge clk_fast) disable iff (!rst_n)
    !(en_fast_g && en_step_g));
  p_excl_step_r7 : assert property (@(posedge clk_step) disable iff (!rst_n)
    !(en_fast_g && en_step_g));

  // R8: status rises only with the fast enable already off.
  p_status_rise_r8 : assert property (@(posedge clk_fast) disable iff (!rst_n)
    $rose(status_q) |-> !en_fast_g);

  // R8: status does not drop while a stepped request is still pending.
  p_status_hold_r8 : assert property (@(posedge clk_fast) disable iff (!rst_n)
    (status_q && req_q) |=> status_q);

  // R2: a request is raised only on a live address phase.
  p_req_live_r2 : assert property (@(posedge clk_fast) disable iff (!rst_n)
    $rose(req_q) |-> ($past(hsel) && $past(hready) && $past(htrans[1])));

endmodule

// File: tb/busclk_switch_test.sv
`timescale 1ns/1ps
module busclk_switch_test;
  localparam int AW = 32;

  logic          clk_fast = 1'b0;
  logic          clk_step = 1'b0;
  logic          rst_n    = 1'b0;
  logic [AW-1:0] haddr    = '0;
  logic [1:0]    htrans   = 2'b00;
  logic          hsel     = 1'b0;
  logic          hready   = 1'b1;
  logic          cfg_wr   = 1'b0;
  logic          cfg_sel  = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          clk_sys;
  logic          step_active;

  int checks = 0;
  int errors = 0;
  int sys_cnt = 0;
  int runts = 0;
  realtime rise_t = 0.0;
  bit finished = 1'b0;

  logic [AW-1:0] lo_m = '1;
  logic [AW-1:0] hi_m = '0;

  busclk_switch #(.ADDR_W(AW), .SYNC_STAGES(2)) uut (
    .clk_fast(clk_fast), .clk_step(clk_step), .rst_n(rst_n),
    .haddr(haddr), .htrans(htrans), .hsel(hsel), .hready(hready),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .clk_sys(clk_sys), .step_active(step_active)
  );

  always #2 clk_fast = ~clk_fast;

  always @(posedge clk_sys) begin
    sys_cnt++;
    rise_t = $realtime;
  end
  always @(negedge clk_sys) if ($realtime - rise_t < 1.9) runts++;

  function automatic bit exp_hit(input logic [AW-1:0] a, input logic [1:0] tr,
                                 input logic s, input logic r);
    bit live;
    live = s && r && tr[1];
    return live && !(a < lo_m) && !(a > hi_m);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [AW-1:0] d, input bit takes);
    @(negedge clk_fast);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk_fast);
    cfg_wr = 1'b0;
    if (takes) begin
      if (sel) hi_m = d; else lo_m = d;
    end
  endtask

  task automatic bus_pulse(input logic [AW-1:0] a, input logic [1:0] tr,
                           input logic s, input logic r);
    @(negedge clk_fast);
    haddr = a; htrans = tr; hsel = s; hready = r;
    @(negedge clk_fast);
    htrans = 2'b00; hsel = 1'b0; hready = 1'b1;
  endtask

  task automatic sys_edges(input int n, output int cnt);
    int c0;
    @(negedge clk_fast);
    c0 = sys_cnt;
    repeat (n) @(negedge clk_fast);
    cnt = sys_cnt - c0;
  endtask

  task automatic step_n(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_fast);
      #1 clk_step = 1'b1;
      #20 clk_step = 1'b0;
      #19;
    end
  endtask

  task automatic go_back();
    @(negedge clk_fast);
    htrans = 2'b00; hsel = 1'b0; hready = 1'b1;
    step_n(8);
    repeat (10) @(negedge clk_fast);
  endtask

  task automatic probe(input bit expect_step, input string req);
    int cnt;
    repeat (8) @(negedge clk_fast);
    sys_edges(5, cnt);
    check(cnt == (expect_step ? 0 : 5), req, cnt, expect_step ? 0 : 5);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int cnt;
    int c0;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk_fast);
    rst_n = 1'b1;

    // R1: reset state
    check(step_active == 1'b0, "R1 status", step_active, 0);
    sys_edges(5, cnt);
    check(cnt == 5, "R1 fast clock", cnt, 5);
    bus_pulse(32'h0000_0000, 2'b10, 1'b1, 1'b1);
    bus_pulse(32'hFFFF_FFFF, 2'b10, 1'b1, 1'b1);
    probe(1'b0, "R1 empty window");

    // R9: program the window while fast
    cfg_write(1'b0, 32'h0000_1000, 1'b1);
    cfg_write(1'b1, 32'h0000_10FF, 1'b1);

    // R2: non-starting patterns
    bus_pulse(32'h1010, 2'b00, 1'b1, 1'b1); probe(1'b0, "R2 idle");
    bus_pulse(32'h1010, 2'b01, 1'b1, 1'b1); probe(1'b0, "R2 busy");
    bus_pulse(32'h1010, 2'b10, 1'b0, 1'b1); probe(1'b0, "R2 hsel low");
    bus_pulse(32'h1010, 2'b11, 1'b1, 1'b0); probe(1'b0, "R2 hready low");

    // R3/R8: hit, fast stops, status still low before any stepped edge
    bus_pulse(32'h1010, 2'b10, 1'b1, 1'b1);
    probe(1'b1, "R3 fast stopped");
    check(step_active == 1'b0, "R8 status waits", step_active, 0);

    // R5: data phase stalled by hready low
    @(negedge clk_fast); hready = 1'b0;
    step_n(6);
    repeat (4) @(negedge clk_fast);
    check(step_active == 1'b1, "R8 status set", step_active, 1);
    c0 = sys_cnt;
    step_n(3);
    check(sys_cnt - c0 == 3, "R3 stepped pulses", sys_cnt - c0, 3);
    check(step_active == 1'b1, "R5 stall holds", step_active, 1);
    sys_edges(5, cnt);
    check(cnt == 0, "R5 no fast pulses", cnt, 0);

    // R9: ignored write while stepped (would exclude 0x1010)
    cfg_write(1'b0, 32'hFFFF_0000, 1'b0);

    // R6: back-to-back window hits keep stepped clock
    @(negedge clk_fast); haddr = 32'h1020; htrans = 2'b11; hsel = 1'b1; hready = 1'b1;
    step_n(4);
    repeat (4) @(negedge clk_fast);
    check(step_active == 1'b1, "R6 back-to-back", step_active, 1);
    sys_edges(5, cnt);
    check(cnt == 0, "R6 no fast return", cnt, 0);

    // R4: completion returns fast clock
    go_back();
    check(step_active == 1'b0, "R4 status cleared", step_active, 0);
    sys_edges(5, cnt);
    check(cnt == 5, "R4 fast back", cnt, 5);

    // R9: old window still active
    bus_pulse(32'h1010, 2'b10, 1'b1, 1'b1);
    probe(1'b1, "R9 write ignored");
    go_back();
    check(step_active == 1'b0, "R9 return", step_active, 0);

    // R10: single-address window
    cfg_write(1'b0, 32'h2000, 1'b1);
    cfg_write(1'b1, 32'h2000, 1'b1);
    bus_pulse(32'h1FFF, 2'b10, 1'b1, 1'b1); probe(1'b0, "R10 below");
    bus_pulse(32'h2001, 2'b10, 1'b1, 1'b1); probe(1'b0, "R10 above");
    bus_pulse(32'h2000, 2'b10, 1'b1, 1'b1); probe(1'b1, "R10 exact");
    go_back();

    // R2: constrained random patterns against the bench model
    cfg_write(1'b0, 32'h3000, 1'b1);
    cfg_write(1'b1, 32'h30FF, 1'b1);
    for (int i = 0; i < 24; i++) begin
      logic [AW-1:0] a;
      logic [1:0]    tr;
      logic          s, r;
      bit            e;
      a  = 32'h2F80 + ($urandom % 32'h200);
      tr = 2'($urandom % 4);
      s  = ($urandom % 4) != 0;
      r  = ($urandom % 4) != 0;
      e  = exp_hit(a, tr, s, r);
      bus_pulse(a, tr, s, r);
      probe(e, "R2 random");
      if (e) begin
        go_back();
        check(step_active == 1'b0, "R4 random return", step_active, 0);
      end
    end

    // R7: no runt pulse seen on the output
    check(runts == 0, "R7 runt pulses", runts, 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule